// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block is the serial configuration port of a clock-buffer device. A system controller on a two-wire SMBus writes and reads a small bank of 8-bit registers. Those registers drive the rest of the device as one flat parallel bus, carrying settings such as per-output enables.

The slave watches oversampled SCL and SDA, which are synchronised into the core clock. It decodes its 7-bit address, which a strap input chooses between two values. The command byte that follows sets three things: single-byte or block mode, a chip-select code that must agree with a pin, and a register offset. The slave answers on SDA through an open-drain pull-down enable. All registers return to their defaults on reset, so a system that never touches the bus still gets a working device.

Top module: `smbus_cfg_slave`

## Requirements
- R1: On reset every register takes its value from `RESET_VALUE` (default 8'hFF in every byte), and the SDA pull-down is released.
- R2: The slave acknowledges an address byte whose upper seven bits equal 7'h69 when `addrSel` is 0, or 7'h6E when `addrSel` is 1 (write/read bytes D2h/D3h or DCh/DDh). Any other address is not acknowledged, and the slave ignores the bus until the next START.
- R3: Command bit 7 selects the mode. A 1 means single-byte access at the offset in bits 4:0. A 0 means block access from register 0, and bits 4:0 are ignored.
- R4: Command bits 6:5 must read 2'b01 when `chipSel` is 0, or 2'b10 when `chipSel` is 1. On a mismatch the command byte is not acknowledged, and nothing more is acknowledged until a STOP, including a repeated address. No register changes.
- R5: A single-byte write stores the first data byte at the command offset. Further data bytes in the same transfer are acknowledged and discarded.
- R6: A block write takes a count byte, then writes that many data bytes to registers 0, 1, 2 and upwards, MSB first. Bytes beyond the count are acknowledged and discarded. A STOP after any whole byte leaves the registers not yet reached unchanged.
- R7: A single-byte read is formed as address+W, command, repeated START, address+R. It returns the register at the command offset.
- R8: A block read returns the register count (8'd8) first, then registers 0, 1, 2 and upwards, for as long as the master acknowledges.
- R9: Offsets at or above the register count are acknowledged on write with no effect, and read as 8'h00.
- R10: The SDA pull-down changes only while the synchronised SCL is low. It is released after a STOP.
- R11: Register i appears on `cfgOut[8*i+7:8*i]`, and any register change is tied to an acknowledged data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that oversamples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | SMBus clock line as seen at the pad |
| sdaIn | input | 1 | SMBus data line as seen at the pad (wired value) |
| sdaDriveLow | output | 1 | Pull-down enable for the open-drain SDA pad |
| addrSel | input | 1 | Strap choosing one of the two slave addresses |
| chipSel | input | 1 | Pin the command chip-select code is compared against |
| cfgOut | output | REG_COUNT*8 | All configuration registers, register 0 in the low byte |

## Verification
The bench builds the block with its default parameters: eight registers, addresses 7'h69 and 7'h6E, and every register resetting to 8'hFF. With eight registers, a 5-bit offset can name both implemented and unimplemented locations, so writes and reads at offsets 8 and 31 are reachable. A block read returning a count of 8 then covers the whole bank. Both strap settings and both chip-select codes are driven, so the mismatch paths of the address and the command field are each exercised against a bank whose contents are known.

// File: rtl/cfgbus_pkg.sv
package cfgbus_pkg;

  // Strobes the controller hands to the datapath, one cycle each.
  typedef struct packed {
    logic rxShiftEn;    // shift the sampled SDA bit into the receive byte
    logic txLoad;       // load the transmit byte
    logic txLoadCount;  // with txLoad: load the register count instead of data
    logic txShiftEn;    // advance the transmit byte by one bit
    logic regWrite;     // store the receive byte into the indexed register
  } dpStrobe_t;

  typedef enum logic [1:0] {PH_IDLE, PH_RX, PH_TX} phase_e;
  typedef enum logic [1:0] {BY_ADDR, BY_CMD, BY_COUNT, BY_DATA} byteKind_e;

endpackage

// File: rtl/cfgbus_sync.sv
module cfgbus_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclS,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startEv,
  output logic stopEv
);
  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclPrev, sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS    = sclPipe[SYNC_STAGES-1];
  assign sdaS    = sdaPipe[SYNC_STAGES-1];
  assign sclRise = sclS & ~sclPrev;
  assign sclFall = ~sclS & sclPrev;
  assign startEv = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopEv  = sclS & sclPrev & ~sdaPrev & sdaS;
endmodule

// File: rtl/cfgbus_regs.sv
module cfgbus_regs
  import cfgbus_pkg::*;
#(
  parameter int REG_COUNT = 8,
  parameter int IDX_W = 3,
  parameter logic [REG_COUNT*8-1:0] RESET_VALUE = {REG_COUNT{8'hFF}}
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpStrobe_t              strobe,
  input  logic [IDX_W-1:0]       idx,
  input  logic                   idxValid,
  input  logic                   sdaS,
  output logic [7:0]             rxByte,
  output logic                   txBit,
  output logic [REG_COUNT*8-1:0] cfgOut
);
  localparam logic [7:0] COUNT_BYTE = 8'(REG_COUNT);

  logic [REG_COUNT-1:0][7:0] regView;
  logic [7:0] rxShift, txShift, readByte;

  for (genvar g = 0; g < REG_COUNT; g++) begin : gReg
    logic [7:0] val;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) val <= RESET_VALUE[8*g +: 8];
      else if (strobe.regWrite && idx == IDX_W'(g)) val <= rxShift;
    end
    assign regView[g] = val;
  end

  assign readByte = idxValid ? regView[idx] : 8'h00;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= 8'h00;
      txShift <= 8'hFF;
    end else begin
      if (strobe.rxShiftEn) rxShift <= {rxShift[6:0], sdaS};
      if (strobe.txLoad) txShift <= strobe.txLoadCount ? COUNT_BYTE : readByte;
      else if (strobe.txShiftEn) txShift <= {txShift[6:0], 1'b1};
    end
  end

  assign rxByte = rxShift;
  assign txBit  = txShift[7];
  assign cfgOut = regView;
endmodule

// File: rtl/cfgbus_ctrl.sv
module cfgbus_ctrl
  import cfgbus_pkg::*;
#(
  parameter int REG_COUNT = 8,
  parameter int IDX_W = 3,
  parameter logic [6:0] ADDR_LOW = 7'h69,
  parameter logic [6:0] ADDR_HIGH = 7'h6E
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclRise,
  input  logic             sclFall,
  input  logic             startEv,
  input  logic             stopEv,
  input  logic             sdaS,
  input  logic [7:0]       rxByte,
  input  logic             txBit,
  input  logic             addrSel,
  input  logic             chipSel,
  output dpStrobe_t        strobe,
  output logic [IDX_W-1:0] idx,
  output logic             idxValid,
  output logic             sdaDriveLow
);
  localparam logic [7:0] LAST_IDX = 8'(REG_COUNT);

  phase_e    phase;
  byteKind_e kind;
  logic [3:0] bitCnt;
  logic [7:0] ptr, remaining;
  logic inAck, ackDrive, isRead, cmdBlock, deselected, masterAck;
  logic ackOk, rxDone, ackEnd, txEnd;
  logic [6:0] myAddr;
  logic [1:0] csCode;

  assign myAddr   = addrSel ? ADDR_HIGH : ADDR_LOW;
  assign csCode   = chipSel ? 2'b10 : 2'b01;
  assign idxValid = ptr < LAST_IDX;
  assign idx      = ptr[IDX_W-1:0];

  assign rxDone = (phase == PH_RX) && sclFall && !inAck && (bitCnt == 4'd8);
  assign ackEnd = (phase == PH_RX) && sclFall && inAck;
  assign txEnd  = (phase == PH_TX) && sclFall && (bitCnt == 4'd8);

  always_comb begin
    case (kind)
      BY_ADDR: ackOk = (rxByte[7:1] == myAddr) && !deselected;
      BY_CMD:  ackOk = (rxByte[6:5] == csCode);
      default: ackOk = 1'b1;
    endcase
  end

  always_comb begin
    strobe.rxShiftEn   = (phase == PH_RX) && sclRise && !inAck && (bitCnt != 4'd8);
    strobe.regWrite    = rxDone && ackOk && (kind == BY_DATA) && (remaining != 8'd0) && idxValid;
    strobe.txLoadCount = ackEnd && (kind == BY_ADDR) && isRead && cmdBlock;
    strobe.txLoad      = (ackEnd && (kind == BY_ADDR) && isRead) || (txEnd && masterAck);
    strobe.txShiftEn   = (phase == PH_TX) && sclFall && (bitCnt < 4'd8);
  end

  assign sdaDriveLow = ackDrive || ((phase == PH_TX) && (bitCnt < 4'd8) && !txBit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase      <= PH_IDLE;
      kind       <= BY_ADDR;
      bitCnt     <= 4'd0;
      ptr        <= 8'd0;
      remaining  <= 8'd0;
      inAck      <= 1'b0;
      ackDrive   <= 1'b0;
      isRead     <= 1'b0;
      cmdBlock   <= 1'b0;
      deselected <= 1'b0;
      masterAck  <= 1'b0;
    end else if (startEv) begin
      phase    <= PH_RX;
      kind     <= BY_ADDR;
      bitCnt   <= 4'd0;
      inAck    <= 1'b0;
      ackDrive <= 1'b0;
    end else if (stopEv) begin
      phase      <= PH_IDLE;
      inAck      <= 1'b0;
      ackDrive   <= 1'b0;
      deselected <= 1'b0;
    end else begin
      if (strobe.rxShiftEn || strobe.txShiftEn) bitCnt <= bitCnt + 4'd1;

      if (rxDone) begin
        if (ackOk) begin
          inAck    <= 1'b1;
          ackDrive <= 1'b1;
          case (kind)
            BY_ADDR: isRead <= rxByte[0];
            BY_CMD: begin
              cmdBlock  <= ~rxByte[7];
              ptr       <= rxByte[7] ? {3'b000, rxByte[4:0]} : 8'd0;
              remaining <= rxByte[7] ? 8'd1 : 8'd0;
            end
            BY_COUNT: remaining <= rxByte;
            default: if (remaining != 8'd0) begin
              remaining <= remaining - 8'd1;
              ptr       <= ptr + 8'd1;
            end
          endcase
        end else begin
          phase <= PH_IDLE;
          if (kind == BY_CMD) deselected <= 1'b1;
        end
      end

      if (ackEnd) begin
        inAck    <= 1'b0;
        ackDrive <= 1'b0;
        bitCnt   <= 4'd0;
        case (kind)
          BY_ADDR: if (isRead) phase <= PH_TX; else kind <= BY_CMD;
          BY_CMD:  kind <= cmdBlock ? BY_COUNT : BY_DATA;
          default: kind <= BY_DATA;
        endcase
      end

      if ((phase == PH_TX) && sclRise && (bitCnt == 4'd8)) masterAck <= ~sdaS;

      if (txEnd) begin
        if (masterAck) bitCnt <= 4'd0;
        else phase <= PH_IDLE;
      end

      if (strobe.txLoad && !strobe.txLoadCount) ptr <= ptr + 8'd1;
    end
  end
endmodule

// File: rtl/smbus_cfg_slave.sv
module smbus_cfg_slave
  import cfgbus_pkg::*;
#(
  parameter int REG_COUNT = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [6:0] ADDR_LOW = 7'h69,
  parameter logic [6:0] ADDR_HIGH = 7'h6E,
  parameter logic [REG_COUNT*8-1:0] RESET_VALUE = {REG_COUNT{8'hFF}}
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   sclIn,
  input  logic                   sdaIn,
  output logic                   sdaDriveLow,
  input  logic                   addrSel,
  input  logic                   chipSel,
  output logic [REG_COUNT*8-1:0] cfgOut
);
  localparam int IDX_W = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1;

  logic sclS, sdaS, sclRise, sclFall, startEv, stopEv;
  logic [7:0] rxByte;
  logic txBit, idxValid;
  logic [IDX_W-1:0] idx;
  dpStrobe_t strobe;

  cfgbus_sync #(.SYNC_STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclS(sclS), .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv)
  );

  cfgbus_ctrl #(
    .REG_COUNT(REG_COUNT), .IDX_W(IDX_W), .ADDR_LOW(ADDR_LOW), .ADDR_HIGH(ADDR_HIGH)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv), .sdaS(sdaS), .rxByte(rxByte),
    .txBit(txBit), .addrSel(addrSel), .chipSel(chipSel), .strobe(strobe),
    .idx(idx), .idxValid(idxValid), .sdaDriveLow(sdaDriveLow)
  );

  cfgbus_regs #(
    .REG_COUNT(REG_COUNT), .IDX_W(IDX_W), .RESET_VALUE(RESET_VALUE)
  ) uRegs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .idx(idx), .idxValid(idxValid),
    .sdaS(sdaS), .rxByte(rxByte), .txBit(txBit), .cfgOut(cfgOut)
  );
endmodule

// File: rtl/cfgbus_chk.sv
module cfgbus_chk #(
  parameter int CFG_W = 64,
  parameter logic [CFG_W-1:0] RESET_VALUE = '1
) (
  input logic             clk,
  input logic             rstN,
  input logic             sclS,
  input logic             stopEv,
  input logic             sdaDriveLow,
  input logic             regWrite,
  input logic [CFG_W-1:0] cfgOut
);
  assert_reset_defaults_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> cfgOut == RESET_VALUE);

  assert_sda_moves_scl_low_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDriveLow) |-> !sclS);

  assert_stop_releases_R10: assert property (@(posedge clk) disable iff (!rstN)
    stopEv |=> !sdaDriveLow);

  assert_change_needs_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cfgOut) |-> $past(regWrite));

  assert_change_with_ack_R11: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cfgOut) |-> sdaDriveLow);
endmodule

bind smbus_cfg_slave cfgbus_chk #(
  .CFG_W(REG_COUNT*8), .RESET_VALUE(RESET_VALUE)
) uChk (
  .clk(clk), .rstN(rstN), .sclS(sclS), .stopEv(stopEv),
  .sdaDriveLow(sdaDriveLow), .regWrite(strobe.regWrite), .cfgOut(cfgOut)
);

// File: tb/smbus_cfg_slave_test.sv
`timescale 1ns/1ps
module smbus_cfg_slave_test;
  localparam int HALF = 8;
  localparam logic [7:0] ADR_LO = 8'hD2;
  localparam logic [7:0] ADR_HI = 8'hDC;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic addrSel = 1'b0, chipSel = 1'b0;
  logic sdaDriveLow;
  logic [63:0] cfgOut;
  logic sdaLine;
  int nChecks = 0, nFails = 0;
  logic [7:0] model [8];
  logic [7:0] txBuf [8];
  logic [7:0] rxBuf [10];
  logic [8:0] wAck;
  logic [2:0] rAck;

  assign sdaLine = sdaM & ~sdaDriveLow;

  always #5 clk = ~clk;

  smbus_cfg_slave uut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .sdaDriveLow(sdaDriveLow), .addrSel(addrSel), .chipSel(chipSel), .cfgOut(cfgOut)
  );

  typedef struct packed {
    logic [4:0] off;
    logic [7:0] wdata;
    logic [7:0] expRead;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{5'd0,  8'hA5, 8'hA5}, '{5'd3,  8'h3C, 8'h3C},
    '{5'd7,  8'h81, 8'h81}, '{5'd8,  8'h55, 8'h00},
    '{5'd31, 8'hF0, 8'h00}, '{5'd1,  8'h00, 8'h00},
    '{5'd6,  8'h7E, 8'h7E}, '{5'd3,  8'hC3, 8'hC3}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [63:0] packModel();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[8*i +: 8] = model[i];
    return v;
  endfunction

  function automatic logic [7:0] cmdByte(input logic single, input logic [4:0] off);
    return {single, (chipSel ? 2'b10 : 2'b01), off};
  endfunction

  task automatic busStart();
    sdaM = 1'b1; tick(HALF/2);
    sclM = 1'b1; tick(HALF/2);
    sdaM = 1'b0; tick(HALF/2);
    sclM = 1'b0;
  endtask

  task automatic busStop();
    tick(HALF/2); sdaM = 1'b0; tick(HALF/2);
    sclM = 1'b1; tick(HALF/2);
    sdaM = 1'b1; tick(HALF);
  endtask

  task automatic clockBit(input logic drive, output logic seen);
    tick(HALF/2); sdaM = drive; tick(HALF/2);
    sclM = 1'b1; tick(HALF/2);
    seen = sdaLine; tick(HALF/2);
    sclM = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) clockBit(b[i], s);
    clockBit(1'b1, s);
    acked = !s;
  endtask

  task automatic recvByte(output logic [7:0] b, input logic ackIt);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clockBit(1'b1, s);
      b[i] = s;
    end
    clockBit(!ackIt, s);
  endtask

  task automatic writeSeq(input logic [7:0] addr8, input int n, output logic [8:0] ackMask);
    logic a;
    ackMask = '0;
    busStart();
    sendByte(addr8, a); ackMask[0] = a;
    for (int i = 0; i < n; i++) begin
      sendByte(txBuf[i], a); ackMask[i+1] = a;
    end
    busStop();
  endtask

  task automatic readSeq(input logic [7:0] addr8, input logic [7:0] cmd, input int n,
                         output logic [2:0] ackMask);
    logic a;
    busStart();
    sendByte(addr8, a); ackMask[0] = a;
    sendByte(cmd, a); ackMask[1] = a;
    busStart();
    sendByte(addr8 | 8'h01, a); ackMask[2] = a;
    for (int i = 0; i < n; i++) recvByte(rxBuf[i], i != n - 1);
    busStop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 8'hFF;
    tick(5);
    // R1 R11: defaults visible on the flat bus, SDA released
    check("R1 reset value", cfgOut, packModel());
    check("R1 sda released", {63'd0, sdaDriveLow}, 64'd0);
    rstN = 1'b1;
    tick(5);

    // Table: single-byte write then single-byte read back (R3 R5 R7 R9 R11)
    for (int v = 0; v < 8; v++) begin
      txBuf[0] = cmdByte(1'b1, VECS[v].off);
      txBuf[1] = VECS[v].wdata;
      writeSeq(ADR_LO, 2, wAck);
      if (VECS[v].off < 5'd8) model[VECS[v].off] = VECS[v].wdata;
      check("R3 byte write acks", {55'd0, wAck}, 64'h7);
      check("R11 bus after write", cfgOut, packModel());
      readSeq(ADR_LO, cmdByte(1'b1, VECS[v].off), 1, rAck);
      check("R7 byte read acks", {61'd0, rAck}, 64'h7);
      check("R9 R7 read data", {56'd0, rxBuf[0]}, {56'd0, VECS[v].expRead});
    end
    check("R10 released when idle", {63'd0, sdaDriveLow}, 64'd0);

    // R2: strap selects the upper address
    addrSel = 1'b1;
    txBuf[0] = cmdByte(1'b1, 5'd3); txBuf[1] = 8'h0F;
    writeSeq(ADR_LO, 2, wAck);
    check("R2 old address nacked", {55'd0, wAck}, 64'h0);
    check("R2 no change", cfgOut, packModel());
    writeSeq(ADR_HI, 2, wAck);
    model[3] = 8'h0F;
    check("R2 new address acked", {55'd0, wAck}, 64'h7);
    check("R2 write via new address", cfgOut, packModel());
    addrSel = 1'b0;

    // R4: chip-select field mismatch, repeated address also refused
    chipSel = 1'b1;
    begin
      logic a0, a1, a2;
      busStart();
      sendByte(ADR_LO, a0);
      sendByte({1'b1, 2'b01, 5'd2}, a1);
      busStart();
      sendByte(ADR_LO, a2);
      busStop();
      check("R4 mismatch acks", {61'd0, a0, a1, a2}, 64'h4);
    end
    check("R4 no change", cfgOut, packModel());
    txBuf[0] = cmdByte(1'b1, 5'd2); txBuf[1] = 8'h77;
    writeSeq(ADR_LO, 2, wAck);
    model[2] = 8'h77;
    check("R4 matching code accepted", {55'd0, wAck}, 64'h7);
    check("R4 write lands", cfgOut, packModel());
    chipSel = 1'b0;

    // R6: block write with a byte past the count
    txBuf[0] = cmdByte(1'b0, 5'd0); txBuf[1] = 8'd3;
    txBuf[2] = 8'h11; txBuf[3] = 8'h22; txBuf[4] = 8'h33; txBuf[5] = 8'h44;
    writeSeq(ADR_LO, 6, wAck);
    model[0] = 8'h11; model[1] = 8'h22; model[2] = 8'h33;
    check("R6 block acks", {55'd0, wAck}, 64'h7F);
    check("R6 block contents", cfgOut, packModel());

    // R6: block write stopped early
    txBuf[0] = cmdByte(1'b0, 5'd0); txBuf[1] = 8'd5;
    txBuf[2] = 8'hA1; txBuf[3] = 8'hB2;
    writeSeq(ADR_LO, 4, wAck);
    model[0] = 8'hA1; model[1] = 8'hB2;
    check("R6 early stop contents", cfgOut, packModel());

    // R5: extra bytes after a single-byte write are discarded
    txBuf[0] = cmdByte(1'b1, 5'd5); txBuf[1] = 8'h5A; txBuf[2] = 8'h99;
    writeSeq(ADR_LO, 3, wAck);
    model[5] = 8'h5A;
    check("R5 extra byte acked", {55'd0, wAck}, 64'hF);
    check("R5 extra byte ignored", cfgOut, packModel());

    // R8: block read returns count then the bank in order
    readSeq(ADR_LO, cmdByte(1'b0, 5'd0), 9, rAck);
    check("R8 block read acks", {61'd0, rAck}, 64'h7);
    check("R8 count byte", {56'd0, rxBuf[0]}, 64'd8);
    begin
      logic [63:0] got;
      for (int i = 0; i < 8; i++) got[8*i +: 8] = rxBuf[i+1];
      check("R8 block data", got, packModel());
    end
    check("R10 released after read", {63'd0, sdaDriveLow}, 64'd0);

    // R1: reset again restores defaults
    rstN = 1'b0;
    tick(2);
    for (int i = 0; i < 8; i++) model[i] = 8'hFF;
    check("R1 second reset", cfgOut, packModel());
    rstN = 1'b1;
    tick(4);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule